// File: doc/BRIEF.md
# Paged Memory Decoder with Bus Demultiplexer

This block connects an 8-bit microcontroller to a paged program ROM, a paged work RAM, a display controller and an instrument-bus interface chip. The controller has a 13-bit address space of 8K bytes. It carries the low address byte on the same eight pins as its data. The block divides the oscillator by five to make the bus clock, which is also the data strobe. It captures the low address byte on the address strobe. It then decodes the full address into active-low chip selects that are only valid while the strobe is high.

Two controller port bits act as page registers. Both bits together choose one of four 4K pages of a 16K ROM behind a 4K window. The lower bit alone chooses one of two 1K pages of a 2K RAM behind a 1K window. The block samples the page bits once per bus cycle and drives the expanded ROM and RAM addresses and the current page numbers. For the interface chip it also drives a three-bit register select taken from the low address bits.

Top module: `paged_mem_decoder`

## Requirements
- R1: `bus_clk` repeats with a period of five `clk` cycles. It is low for the first three cycles after reset and high for the next two.
- R2: The low address byte on `ad_bus` is captured on a `clk` edge where `ale` is high. It is held unchanged while `ale` is low, so later data on `ad_bus` leaves it alone. It is visible as `rom_addr[7:0]`.
- R3: Full address = {`addr_hi`, latched byte}. Addresses 0x1000–0x1FFF assert `rom_cs_n`. `rom_addr` = page*4096 + (address mod 4096), where page = `pg_sel` (bit 1 high, bit 0 low).
- R4: Addresses 0x0800–0x0BFF assert `ram_cs_n`. `ram_addr` = page bit 0 * 1024 + (address mod 1024).
- R5: Addresses 0x0C00–0x0C07 assert `ifc_cs_n`. `ifc_rs` always equals the address mod 8.
- R6: Addresses 0x0C08–0x0C0F assert `disp_cs_n`.
- R7: Every other address, including the on-chip range 0x0000–0x007F, leaves all four selects high.
- R8: Selects are active low. They may go low only while `bus_clk` is high, and at most one is low at a time.
- R9: `pg_sel` is sampled only on the `clk` edge that ends a bus cycle, where `bus_clk` falls. A change at any other time takes effect from the next bus cycle. `rom_page` and `ram_page` show the sampled value.
- R10: Synchronous active-high `rst` clears the divider, the latched byte and the page registers, and forces all selects high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address strobe from the controller |
| ad_bus | input | 8 | Multiplexed low address / data bus |
| addr_hi | input | 5 | Upper address lines A12..A8 |
| pg_sel | input | 2 | Port bits used as page selects (bit 1 high) |
| bus_clk | output | 1 | Divided bus clock and data strobe |
| rom_cs_n | output | 1 | Program ROM select, active low |
| ram_cs_n | output | 1 | Work RAM select, active low |
| ifc_cs_n | output | 1 | Instrument-bus interface select, active low |
| disp_cs_n | output | 1 | Display controller select, active low |
| rom_page | output | 2 | Current ROM page |
| ram_page | output | 1 | Current RAM page |
| rom_addr | output | 14 | Expanded ROM address |
| ram_addr | output | 11 | Expanded RAM address |
| ifc_rs | output | 3 | Interface chip register select |

## Verification
Bus cycles are driven at fixed addresses on both sides of every window edge: 0x007F/0x0080, 0x07FF/0x0800, 0x0BFF/0x0C00, 0x0C07/0x0C08, 0x0C0F/0x0C10 and 0x0FFF/0x1000. Each pair shows whether a window is off by one at either end. Pseudo-random addresses and page values then exercise the page arithmetic, and a wrong page bit or a swapped page order shows up in the expanded addresses. Some cycles change the page bits in mid-cycle and put different data on the shared bus during the data phase. These separate correct per-cycle sampling from transparent pass-through, in both the page registers and the address latch. A reset in mid-run checks that the divider phase is restored.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

    localparam int ADDR_W   = 13;
    localparam int LO_W     = 8;
    localparam int HI_W     = ADDR_W - LO_W;
    localparam int ROM_PG_W = 2;
    localparam int RAM_PG_W = 1;
    localparam int ROM_WIN_LOG2 = 12;
    localparam int RAM_WIN_LOG2 = 10;
    localparam int REG_SEL_W    = 3;
    localparam int ROM_ADDR_W   = ROM_WIN_LOG2 + ROM_PG_W;
    localparam int RAM_ADDR_W   = RAM_WIN_LOG2 + RAM_PG_W;

    localparam logic [ADDR_W-1:0] ROM_BASE  = 13'h1000;
    localparam logic [ADDR_W-1:0] RAM_BASE  = 13'h0800;
    localparam logic [ADDR_W-1:0] IFC_BASE  = 13'h0C00;
    localparam logic [ADDR_W-1:0] DISP_BASE = 13'h0C08;

    typedef struct packed {
        logic rom;
        logic ram;
        logic ifc;
        logic disp;
    } sel_t;

    function automatic logic in_window(logic [ADDR_W-1:0] a,
                                       logic [ADDR_W-1:0] base,
                                       int unsigned size_log2);
        return (a >> size_log2) == (base >> size_log2);
    endfunction

endpackage

// File: rtl/bus_clk_div.sv
module bus_clk_div #(
    parameter int DIV  = 5,
    parameter int HIGH = 2
) (
    input  logic clk,
    input  logic rst,
    output logic ds_o,
    output logic wrap_o
);
    localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int LOW = DIV - HIGH;

    logic [CW-1:0] cnt_q, cnt_nxt;

    always_comb begin
        if (cnt_q == CW'(DIV - 1)) cnt_nxt = '0;
        else                       cnt_nxt = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ds_o  <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            ds_o  <= (cnt_nxt >= CW'(LOW));
        end
    end

    assign wrap_o = (cnt_q == CW'(DIV - 1));

    // R1: a rising strobe stays high on the following cycle
    a_r1_high_holds: assert property (@(posedge clk) disable iff (rst)
        $rose(ds_o) |=> ds_o);
    // R1: the cycle-ending count sits inside the high phase
    a_r1_wrap_in_high: assert property (@(posedge clk) disable iff (rst)
        wrap_o |-> ds_o);
    // R10: reset leaves the strobe low
    a_r10_reset_low: assert property (@(posedge clk)
        rst |=> !ds_o);
endmodule

// File: rtl/lo_addr_latch.sv
module lo_addr_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ale,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (ale) q <= d;
    end

    // R2: without the address strobe the captured byte holds
    a_r2_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !ale |=> $stable(q));
endmodule

// File: rtl/page_decode.sv
module page_decode
    import pmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wrap,
    input  logic                  ds,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [ROM_PG_W-1:0]   pg_in,
    output logic                  rom_cs_n,
    output logic                  ram_cs_n,
    output logic                  ifc_cs_n,
    output logic                  disp_cs_n,
    output logic [ROM_PG_W-1:0]   rom_page,
    output logic [RAM_PG_W-1:0]   ram_page,
    output logic [ROM_ADDR_W-1:0] rom_addr,
    output logic [RAM_ADDR_W-1:0] ram_addr,
    output logic [REG_SEL_W-1:0]  ifc_rs
);
    logic [ROM_PG_W-1:0] page_q;
    sel_t                hit, sel;

    always_ff @(posedge clk) begin
        if (rst)       page_q <= '0;
        else if (wrap) page_q <= pg_in;
    end

    always_comb begin
        hit.rom  = in_window(addr, ROM_BASE,  ROM_WIN_LOG2);
        hit.ram  = in_window(addr, RAM_BASE,  RAM_WIN_LOG2);
        hit.ifc  = in_window(addr, IFC_BASE,  REG_SEL_W);
        hit.disp = in_window(addr, DISP_BASE, REG_SEL_W);
        sel      = ds ? hit : '0;
    end

    assign rom_cs_n  = ~sel.rom;
    assign ram_cs_n  = ~sel.ram;
    assign ifc_cs_n  = ~sel.ifc;
    assign disp_cs_n = ~sel.disp;

    assign rom_page = page_q;
    assign ram_page = page_q[RAM_PG_W-1:0];
    assign rom_addr = {page_q, addr[ROM_WIN_LOG2-1:0]};
    assign ram_addr = {page_q[RAM_PG_W-1:0], addr[RAM_WIN_LOG2-1:0]};
    assign ifc_rs   = addr[REG_SEL_W-1:0];

    // R8: no select during the address phase
    a_r8_qualified: assert property (@(posedge clk) disable iff (rst)
        !ds |-> (rom_cs_n && ram_cs_n && ifc_cs_n && disp_cs_n));
    // R8: never two selects at once
    a_r8_one_sel: assert property (@(posedge clk) disable iff (rst)
        $onehot0({~rom_cs_n, ~ram_cs_n, ~ifc_cs_n, ~disp_cs_n}));
    // R9: page registers move only at the end of a bus cycle
    a_r9_page_hold: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(page_q));
endmodule

// File: rtl/paged_mem_decoder.sv
module paged_mem_decoder
    import pmd_pkg::*;
#(
    parameter int DIV  = 5,
    parameter int HIGH = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ale,
    input  logic [LO_W-1:0]       ad_bus,
    input  logic [HI_W-1:0]       addr_hi,
    input  logic [ROM_PG_W-1:0]   pg_sel,
    output logic                  bus_clk,
    output logic                  rom_cs_n,
    output logic                  ram_cs_n,
    output logic                  ifc_cs_n,
    output logic                  disp_cs_n,
    output logic [ROM_PG_W-1:0]   rom_page,
    output logic [RAM_PG_W-1:0]   ram_page,
    output logic [ROM_ADDR_W-1:0] rom_addr,
    output logic [RAM_ADDR_W-1:0] ram_addr,
    output logic [REG_SEL_W-1:0]  ifc_rs
);
    logic            wrap;
    logic [LO_W-1:0] lo_q;

    bus_clk_div #(.DIV(DIV), .HIGH(HIGH)) u_div (
        .clk    (clk),
        .rst    (rst),
        .ds_o   (bus_clk),
        .wrap_o (wrap)
    );

    lo_addr_latch #(.W(LO_W)) u_latch (
        .clk (clk),
        .rst (rst),
        .ale (ale),
        .d   (ad_bus),
        .q   (lo_q)
    );

    page_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .wrap      (wrap),
        .ds        (bus_clk),
        .addr      ({addr_hi, lo_q}),
        .pg_in     (pg_sel),
        .rom_cs_n  (rom_cs_n),
        .ram_cs_n  (ram_cs_n),
        .ifc_cs_n  (ifc_cs_n),
        .disp_cs_n (disp_cs_n),
        .rom_page  (rom_page),
        .ram_page  (ram_page),
        .rom_addr  (rom_addr),
        .ram_addr  (ram_addr),
        .ifc_rs    (ifc_rs)
    );
endmodule

// File: tb/paged_mem_decoder_tb.sv
module paged_mem_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ale = 1'b0;
    logic [7:0] ad_bus = '0;
    logic [4:0] addr_hi = '0;
    logic [1:0] pg_sel = '0;

    logic        bus_clk, rom_cs_n, ram_cs_n, ifc_cs_n, disp_cs_n, ram_page;
    logic [1:0]  rom_page;
    logic [13:0] rom_addr;
    logic [10:0] ram_addr;
    logic [2:0]  ifc_rs;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_cnt = 0;
    int m_lo  = 0;
    int m_pg  = 0;

    always #2 clk = ~clk;

    paged_mem_decoder dut_i (
        .clk(clk), .rst(rst), .ale(ale), .ad_bus(ad_bus), .addr_hi(addr_hi),
        .pg_sel(pg_sel), .bus_clk(bus_clk), .rom_cs_n(rom_cs_n),
        .ram_cs_n(ram_cs_n), .ifc_cs_n(ifc_cs_n), .disp_cs_n(disp_cs_n),
        .rom_page(rom_page), .ram_page(ram_page), .rom_addr(rom_addr),
        .ram_addr(ram_addr), .ifc_rs(ifc_rs)
    );

    // behavioural reference model
    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= 0; m_lo <= 0; m_pg <= 0;
        end else begin
            if (m_cnt == 4) m_pg <= int'(pg_sel);
            if (ale) m_lo <= int'(ad_bus);
            m_cnt <= (m_cnt + 1) % 5;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        int a = int'(addr_hi) * 256 + m_lo;
        int ds = (m_cnt >= 3) ? 1 : 0;
        bit rom_w = (a >= 'h1000 && a < 'h2000);
        bit ram_w = (a >= 'h0800 && a < 'h0C00);
        bit ifc_w = (a >= 'h0C00 && a < 'h0C08);
        bit dsp_w = (a >= 'h0C08 && a < 'h0C10);
        chk("R1 bus_clk", int'(bus_clk), ds);
        chk("R2 latched low byte", int'(rom_addr[7:0]), m_lo);
        chk("R3 rom_cs_n", int'(rom_cs_n), (ds && rom_w) ? 0 : 1);
        chk("R3 rom_addr", int'(rom_addr), m_pg * 4096 + (a % 4096));
        chk("R4 ram_cs_n", int'(ram_cs_n), (ds && ram_w) ? 0 : 1);
        chk("R4 ram_addr", int'(ram_addr), (m_pg % 2) * 1024 + (a % 1024));
        chk("R5 ifc_cs_n", int'(ifc_cs_n), (ds && ifc_w) ? 0 : 1);
        chk("R5 ifc_rs", int'(ifc_rs), a % 8);
        chk("R6 disp_cs_n", int'(disp_cs_n), (ds && dsp_w) ? 0 : 1);
        chk("R9 rom_page", int'(rom_page), m_pg);
        chk("R9 ram_page", int'(ram_page), m_pg % 2);
        if (!(rom_w || ram_w || ifc_w || dsp_w))
            chk("R7 unmapped all high",
                int'({rom_cs_n, ram_cs_n, ifc_cs_n, disp_cs_n}), 'hF);
        if (ds == 0)
            chk("R8 idle phase all high",
                int'({rom_cs_n, ram_cs_n, ifc_cs_n, disp_cs_n}), 'hF);
    endtask

    task automatic step();
        @(negedge clk);
        compare();
    endtask

    // one bus cycle: address phase, then data phase with other bus data
    task automatic bus_cycle(int addr, int pg, bit pg_mid);
        while (m_cnt != 0) step();
        ale     = 1'b1;
        ad_bus  = 8'(addr % 256);
        addr_hi = 5'(addr / 256);
        if (!pg_mid) pg_sel = 2'(pg);
        step();
        ale    = 1'b0;
        ad_bus = 8'((addr * 7 + 91) % 256);
        step();
        if (pg_mid) pg_sel = 2'(pg);
        step(); step(); step();
    endtask

    initial begin
        int edges[12] = '{'h007F, 'h0080, 'h07FF, 'h0800, 'h0BFF, 'h0C00,
                          'h0C07, 'h0C08, 'h0C0F, 'h0C10, 'h0FFF, 'h1000};
        int lfsr = 'h1ACE;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: state right after reset
        step();
        chk("R10 bus_clk low after reset", int'(bus_clk), 0);
        chk("R10 selects high after reset",
            int'({rom_cs_n, ram_cs_n, ifc_cs_n, disp_cs_n}), 'hF);
        chk("R10 page cleared", int'(rom_page), 0);
        // R3..R7 window edges, each page value
        for (int i = 0; i < 12; i++) bus_cycle(edges[i], i % 4, 1'b0);
        bus_cycle('h0000, 1, 1'b0);
        bus_cycle('h1FFF, 3, 1'b0);
        // R9 page changed during the data phase
        for (int i = 0; i < 8; i++) bus_cycle('h1234 + i * 'h111, i % 4, 1'b1);
        // pseudo-random addresses and pages
        for (int i = 0; i < 60; i++) begin
            lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 'hFFFF;
            bus_cycle(lfsr % 8192, (lfsr >> 13) % 4, lfsr[0]);
        end
        // R10 mid-run reset
        bus_cycle('h1800, 2, 1'b0);
        step(); step();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        step();
        chk("R10 mid-run reset page", int'(rom_page), 0);
        chk("R10 mid-run reset latch", int'(rom_addr[7:0]), 0);
        for (int i = 0; i < 6; i++) bus_cycle('h0C00 + i * 3, i % 4, 1'b0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule